// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation converter whose DAC, sample-and-hold and subtraction are all done by one binary-weighted capacitor array. On a start request it steps the array through three modes in turn. First it tracks the input (sample). Then it grounds the array so that the comparator node carries the negated input (hold). Last it runs a binary search (bit cycling), one code bit per clock, from the most significant bit down to the least significant bit.

During bit cycling the block sets the bit under test to 1 and drives the new code to the array. On the next clock edge it reads the comparator and decides that bit. A comparator node below zero means the held input is above the trial level, so the bit stays at 1; otherwise it goes back to 0. The same edge sets the next lower bit as the new trial. After the last bit the finished code is registered on the result bus with a one-clock valid strobe. The result is the largest code that lies strictly below the held input, which is within one LSB of it.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is held low and on the first clock after it, all three mode outputs are 0, `dac_code` is 0, `result` is 0 and `result_vld` is 0.
- R2: A start seen at a clock edge while idle makes `mode_sample` 1 from that edge for exactly SAMPLE_CLKS clocks (default 2).
- R3: Hold mode follows sample mode. `mode_hold` is 1 for exactly one clock, and during that clock `dac_code` is 0.
- R4: `dac_code` is 0 whenever `mode_cycle` is 0.
- R5: The first bit-cycling clock drives `dac_code` with only the MSB (bit WIDTH-1) set.
- R6: A bit under test is kept at 1 exactly when `cmp_below` is 1 at the clock edge one clock after that bit was set. If `cmp_below` is held at 1 the result is all ones; if it is held at 0 the result is 0.
- R7: Bit cycling lasts exactly WIDTH clocks. `result_vld` goes high SAMPLE_CLKS+WIDTH+1 clocks after the start edge.
- R8: With the comparator reporting "input above code", the result is the largest code strictly below the input held at the end of sample mode. An input of k+0.5 LSB gives k. An exact input of k gives k-1, or 0 when k is 0. Changes of the input after sample mode have no effect.
- R9: `result_vld` is high for one clock only. `result` keeps its value until the next conversion finishes.
- R10: A start seen while a conversion is in progress is ignored. It neither restarts nor lengthens the conversion, and no sample mode follows the end of that conversion.
- R11: At most one of `mode_sample`, `mode_hold` and `mode_cycle` is 1 in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, accepted only while idle |
| cmp_below | input | 1 | Comparator: array node is below zero |
| dac_code | output | WIDTH | Code driven to the capacitor array |
| mode_sample | output | 1 | Array tracks the input |
| mode_hold | output | 1 | Array bottom plates grounded |
| mode_cycle | output | 1 | Bit cycling in progress |
| result | output | WIDTH | Last finished conversion code |
| result_vld | output | 1 | One-clock strobe: `result` updated |

## Verification
A corrupted phase or sample counter shows at once on the mode lines. It appears as a sample window of the wrong length, a missing or doubled hold clock, or two mode lines high together, and the bench catches it within the same conversion because it checks the mode lines clock by clock. A wrong trial mask or kept bit shows on `dac_code` by the next clock. It then carries into `result`, which a behavioural comparator and held input expose as a value off by a known amount after WIDTH cycling clocks. A fault in the accept logic shows as a second sample window or as a shifted valid strobe.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation sequencer.
// Assumes nothing beyond a single clock domain.
package sar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_HOLD   = 2'd2,
        PH_CYCLE  = 2'd3
    } sar_phase_e;
endpackage

// File: rtl/sar_phase_timer.sv
// Phase sequencer: idle -> sample (SAMPLE_CLKS clocks) -> hold (1 clock)
// -> bit cycling until the search reports its last bit.
// Assumes SAMPLE_CLKS >= 1 and a synchronous active-low reset.
module sar_phase_timer
    import sar_pkg::*;
#(
    parameter int SAMPLE_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       last_bit,
    output sar_phase_e phase,
    output logic       finish
);
    localparam int CW = (SAMPLE_CLKS > 1) ? $clog2(SAMPLE_CLKS) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(SAMPLE_CLKS - 1);

    sar_phase_e   phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-phase and sample-counter decision.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                cnt_d = '0;
                if (start) phase_d = PH_SAMPLE;
            end
            PH_SAMPLE: begin
                if (cnt_q == CNT_END) begin
                    phase_d = PH_HOLD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_HOLD:  phase_d = PH_CYCLE;
            PH_CYCLE: if (last_bit) phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign phase  = phase_q;
    assign finish = (phase_q == PH_CYCLE) && last_bit;
endmodule

// File: rtl/sar_bit_search.sv
// Binary-search code register. A one-hot mask marks the bit under test.
// Each step decides the masked bit from the comparator and sets the next
// lower bit as the new trial. The code is zero outside bit cycling.
// Assumes load is high for exactly the clock before cycling begins.
module sar_bit_search #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             keep,
    output logic [WIDTH-1:0] code,
    output logic             last_bit,
    output logic [WIDTH-1:0] final_word
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] code_q, mask_q, code_nxt;

    // Per-bit next value: decide the tested bit, set the next trial bit.
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic trial_here;
        if (g == WIDTH - 1) begin : g_top
            assign trial_here = 1'b0;
        end else begin : g_low
            assign trial_here = mask_q[g+1];
        end
        assign code_nxt[g] = mask_q[g] ? keep :
                             (trial_here ? 1'b1 : code_q[g]);
    end

    // Code and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (load) begin
            code_q <= MSB_ONLY;
            mask_q <= MSB_ONLY;
        end else if (step && !mask_q[0]) begin
            code_q <= code_nxt;
            mask_q <= mask_q >> 1;
        end else begin
            code_q <= '0;
            mask_q <= '0;
        end
    end

    assign code       = code_q;
    assign last_bit   = mask_q[0];
    assign final_word = code_nxt;
endmodule

// File: rtl/sar_result_reg.sv
// Output stage: captures the finished code and pulses valid for one clock.
// Assumes capture is a single-clock pulse.
module sar_result_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] result,
    output logic             result_vld
);
    // Result hold register and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            result_vld <= 1'b0;
        end else begin
            result_vld <= capture;
            if (capture) result <= word_in;
        end
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
// Top of the successive-approximation sequencer. It ties the phase timer,
// the binary-search register and the result stage together and decodes
// the mode lines. Assumes cmp_below has settled one clock after each
// dac_code change.
module sar_seq_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SAMPLE_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_below,
    output logic [WIDTH-1:0] dac_code,
    output logic             mode_sample,
    output logic             mode_hold,
    output logic             mode_cycle,
    output logic [WIDTH-1:0] result,
    output logic             result_vld
);
    sar_phase_e       phase;
    logic             finish, last_bit;
    logic [WIDTH-1:0] final_word;

    sar_phase_timer #(.SAMPLE_CLKS(SAMPLE_CLKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .last_bit (last_bit),
        .phase    (phase),
        .finish   (finish)
    );

    sar_bit_search #(.WIDTH(WIDTH)) u_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (phase == PH_HOLD),
        .step       (phase == PH_CYCLE),
        .keep       (cmp_below),
        .code       (dac_code),
        .last_bit   (last_bit),
        .final_word (final_word)
    );

    sar_result_reg #(.WIDTH(WIDTH)) u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (finish),
        .word_in    (final_word),
        .result     (result),
        .result_vld (result_vld)
    );

    assign mode_sample = (phase == PH_SAMPLE);
    assign mode_hold   = (phase == PH_HOLD);
    assign mode_cycle  = (phase == PH_CYCLE);
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
// Port-level property checker for sar_seq_ctrl, bound to every instance.
module sar_seq_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] dac_code,
    input logic             mode_sample,
    input logic             mode_hold,
    input logic             mode_cycle,
    input logic [WIDTH-1:0] result,
    input logic             result_vld
);
    assert_mode_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_sample, mode_hold, mode_cycle}));

    assert_code_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_cycle |-> dac_code == '0);

    assert_hold_one_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_hold |=> mode_cycle);

    assert_hold_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_hold) |-> $past(mode_sample));

    assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |=> !result_vld);

    assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld |-> $stable(result));

    assert_vld_after_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_vld) |-> $past(mode_cycle) && !mode_cycle);

    assert_sample_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_sample) |-> $past(!mode_hold && !mode_cycle));
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dac_code    (dac_code),
    .mode_sample (mode_sample),
    .mode_hold   (mode_hold),
    .mode_cycle  (mode_cycle),
    .result      (result),
    .result_vld  (result_vld)
);

// File: tb/sim_sar_seq_ctrl.sv
// Directed bench: behavioural sample-and-hold and comparator around the DUT.
module sim_sar_seq_ctrl;
    localparam int W  = 8;
    localparam int SC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_below;
    logic [W-1:0] dac_code, result;
    logic         mode_sample, mode_hold, mode_cycle, result_vld;

    int  vin_x2  = 0;      // input in half-LSB units
    int  held_x2 = 0;
    bit  use_model = 1'b1;
    bit  forced    = 1'b0;
    int  total = 0, bad = 0;
    longint cyc = 0;

    always #2.5 clk = ~clk;

    // Sample-and-hold model: track while in sample mode.
    always @(posedge clk) if (mode_sample) held_x2 <= vin_x2;
    // Comparator model: node below zero when held input exceeds the code.
    assign cmp_below = use_model ? (held_x2 > 2 * int'(dac_code)) : forced;

    sar_seq_ctrl #(.WIDTH(W), .SAMPLE_CLKS(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_below(cmp_below),
        .dac_code(dac_code), .mode_sample(mode_sample), .mode_hold(mode_hold),
        .mode_cycle(mode_cycle), .result(result), .result_vld(result_vld)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // One full conversion, mode lines checked clock by clock.
    // late_x2 >= 0 replaces the input after sampling; poke pulses start mid-run.
    task automatic convert(input int in_x2, input int exp_res, input int late_x2,
                           input bit poke, input string tag);
        vin_x2 = in_x2;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k <= SC + W + 1; k++) begin
            if (k > 0) @(negedge clk);
            if (k < SC)
                chk(mode_sample && !mode_hold && !mode_cycle, {tag, " R2 sample window"}, k, SC);
            else if (k == SC) begin
                chk(mode_hold && !mode_sample && !mode_cycle, {tag, " R3 hold"}, k, SC);
                chk(dac_code == 0, {tag, " R3 hold code zero"}, dac_code, 0);
            end else if (k == SC + 1)
                chk(mode_cycle && dac_code == {1'b1, {(W-1){1'b0}}}, {tag, " R5 msb trial"},
                    dac_code, 1 << (W-1));
            if (k <= SC + W)
                chk(!result_vld, {tag, " R7 no early valid"}, k, SC + W + 1);
            if (k > SC && k <= SC + W)
                chk(mode_cycle, {tag, " R7 cycle length"}, k, SC + W);
            if (k == SC + 1 && late_x2 >= 0) vin_x2 = late_x2;
            if (k == 3 && poke) start = 1'b1;
            if (k == 4) start = 1'b0;
        end
        chk(result_vld, {tag, " R7 valid time"}, result_vld, 1);
        chk(result == exp_res, {tag, " R8 result"}, result, exp_res);
        chk(!mode_cycle && dac_code == 0, {tag, " R4 code zero after"}, dac_code, 0);
        @(negedge clk);
        chk(!result_vld, {tag, " R9 valid one clock"}, result_vld, 0);
        chk(result == exp_res, {tag, " R9 result held"}, result, exp_res);
        chk(!mode_sample, {tag, " R10 no restart"}, mode_sample, 0);
        repeat (3) @(negedge clk);
        chk(result == exp_res && !mode_sample, {tag, " R9 R10 idle hold"}, result, exp_res);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mode_sample && !mode_hold && !mode_cycle && dac_code == 0 &&
            result == 0 && !result_vld, "R1 in reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mode_sample && !mode_hold && !mode_cycle && !result_vld,
            "R1 after reset", result_vld, 0);
    endtask

    task automatic t_values;
        convert(2*37 + 1, 37, -1, 0, "mid37");
        convert(1, 0, -1, 0, "mid0");
        convert(2*255 + 1, 255, -1, 0, "full");
        convert(2*128 + 1, 128, -1, 0, "mid128");
        convert(2*100, 99, -1, 0, "exact100");
        convert(2*128, 127, -1, 0, "exact128");
        convert(0, 0, -1, 0, "exact0");
        convert(2*170 + 1, 170, -1, 0, "alt170");
    endtask

    task automatic t_late_input;  // R8: input moved after sampling
        convert(2*85 + 1, 85, 2*200 + 1, 0, "late R8");
    endtask

    task automatic t_busy_start;  // R10: start during conversion
        convert(2*60 + 1, 60, -1, 1, "busy R10");
    endtask

    task automatic t_forced;      // R6: comparator held constant
        use_model = 1'b0;
        forced = 1'b1; convert(0, (1 << W) - 1, -1, 0, "forced1 R6");
        forced = 1'b0; convert(2*255 + 1, 0, -1, 0, "forced0 R6");
        use_model = 1'b1;
    endtask

    task automatic t_mode_exclusive;  // R11 spot check over a conversion
        int seen = 0;
        vin_x2 = 21;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < SC + W + 4; k++) begin
            if ((int'(mode_sample) + int'(mode_hold) + int'(mode_cycle)) > 1) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R11 mode lines exclusive", seen, 0);
        chk(result == 10, "R8 result 10.5", result, 10);
    endtask

    initial begin
        t_reset();
        t_values();
        t_late_input();
        t_busy_start();
        t_forced();
        t_mode_exclusive();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule